// File: doc/BRIEF.md
# MMIO to Scan-Com Register Bus Bridge

This block sits between a host memory-mapped port and an internal scan-com register bus. Every host access is one 64-bit word at an 8-byte aligned byte address. The bridge first cuts the address down to its window. It then folds the address into a register index, using one of two mapping styles chosen by a mode input. A flat mapping simply divides the address by eight. A legacy mapping packs the index differently and drops address bit 7. The word carries its most significant byte first, in bits 63:56. The bridge passes data through unchanged.

A small local responder answers a few indexes by itself. These are a chip identification word, four region base and size words, and a group of status, log, error and mask indexes that read as zero. Every other access goes out on the downstream bus as one request at byte address index×8. The bridge then waits for an acknowledge or an error, or until a timeout counter expires. Only one access is in flight at a time. The host sees a one-cycle ready pulse when its access ends.

Each finished access sets a sticky done bit. An access that failed also sets a sticky fail bit. Software clears these bits by writing ones on a separate status clear port.

Top module: `scom_bridge`

## Requirements
- R1: After reset, h_ready, d_req, st_done and st_fail are all 0.
- R2: With legacy_mode=0, the index is bits [WIN_BITS-1:3] of the address, and a forwarded access drives d_addr = index×8.
- R3: With legacy_mode=1, index bits [3:0] are address bits [6:3] and index bits [IDX_W-2:4] are address bits [WIN_BITS-1:8]. Address bit 7 has no effect.
- R4: Host address bits at or above WIN_BITS have no effect on the index.
- R5: Index 0x000F000F reads CHIP_ID. A write to it is dropped, is not forwarded, and a later read still returns CHIP_ID.
- R6: Indexes 0x00090012, 0x00090013, 0x00090018, 0x000F0033, 0x000F0034, 0x01010C00 and 0x01010C03 read as zero. Writes to them are dropped. No access to them is forwarded.
- R7: Reads of indexes 0x05012B00, 0x05012B04, 0x05012B02 and 0x05012B06 return REGION_A_BASE, REGION_A_SIZE, REGION_B_BASE and REGION_B_SIZE, in that order, without forwarding. Writes to these indexes are forwarded.
- R8: A forwarded read returns d_rdata from the acknowledge cycle, and a forwarded write drives h_wdata on d_wdata. d_req and d_addr hold steady until d_ack, d_err or the timeout.
- R9: When a downstream access ends with d_err, the access completes with h_rdata=0 and sets st_fail.
- R10: An address with bits [2:0] not zero completes with h_rdata=0 and sets st_fail. It is never forwarded.
- R11: If no response arrives within TIMEOUT_CYC cycles of d_req, the bridge drops d_req and completes with h_rdata=0 and st_fail set.
- R12: Every completion sets st_done. st_done and st_fail stay set until st_clr_wr is asserted with the matching st_clr_mask bit (bit 0 for done, bit 1 for fail). When a set and a clear fall in the same cycle, the set wins.
- R13: h_ready is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | 1 selects legacy index folding, 0 selects flat |
| h_valid | input | 1 | Host access request, held until h_ready |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 64 | Host write word |
| h_ready | output | 1 | One-cycle completion pulse |
| h_rdata | output | 64 | Read word, valid while h_ready is high |
| d_req | output | 1 | Downstream request, held until response |
| d_write | output | 1 | Downstream write flag |
| d_addr | output | WIN_BITS | Downstream byte address (index×8) |
| d_wdata | output | 64 | Downstream write word |
| d_ack | input | 1 | Downstream success response |
| d_err | input | 1 | Downstream error response |
| d_rdata | input | 64 | Downstream read word |
| st_clr_wr | input | 1 | Status clear strobe |
| st_clr_mask | input | 2 | Write-1-to-clear mask: bit0 done, bit1 fail |
| st_done | output | 1 | Sticky done flag |
| st_fail | output | 1 | Sticky fail flag |

## Verification
The bound checker checks these properties on every cycle:
- the ready pulse lasts one cycle;
- done rises after every completion;
- fail stays set until a clear;
- misaligned and locally answered accesses never raise d_req;
- a pending request keeps its address steady;
- a downstream error yields zero data and a fail flag;
- no request lasts longer than the timeout window.

The bench scenarios show the rest. They check that both folding styles produce the right downstream address and that high address bits and address bit 7 are ignored. They check the chip identification, region and zero-read values, that local writes are dropped while region writes go out, and that a set wins over a clear in the same cycle.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} scb_state_e;

  localparam logic [31:0] IX_CHIP_ID   = 32'h000F_000F;
  localparam logic [31:0] IX_RGN_A_BAS = 32'h0501_2B00;
  localparam logic [31:0] IX_RGN_B_BAS = 32'h0501_2B02;
  localparam logic [31:0] IX_RGN_A_SZ  = 32'h0501_2B04;
  localparam logic [31:0] IX_RGN_B_SZ  = 32'h0501_2B06;

  // indexes that read as zero and swallow writes
  function automatic logic is_quiet_idx(input logic [31:0] ix);
    case (ix)
      32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
      32'h000F_0033, 32'h000F_0034,
      32'h0101_0C00, 32'h0101_0C03: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/scb_addr_fold.sv
module scb_addr_fold #(
  parameter int ADDR_W   = 40,
  parameter int WIN_BITS = 32,
  localparam int IDX_W   = WIN_BITS - 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              legacy_i,
  output logic [IDX_W-1:0]  idx_o
);
  function automatic logic [IDX_W-1:0] fold_idx(input logic [ADDR_W-1:0] a, input logic leg);
    logic [WIN_BITS-1:0] w;
    w = a[WIN_BITS-1:0];               // window mask
    if (leg) return {1'b0, w[WIN_BITS-1:8], w[6:3]};
    else     return w[WIN_BITS-1:3];
  endfunction

  assign idx_o = fold_idx(addr_i, legacy_i);
endmodule

// File: rtl/scb_local_resp.sv
module scb_local_resp
  import scb_pkg::*;
#(
  parameter int          IDX_W         = 29,
  parameter logic [63:0] CHIP_ID       = 64'h1200_04A6_0000_0049,
  parameter logic [63:0] REGION_A_BASE = 64'h0000_0800_0000_0000,
  parameter logic [63:0] REGION_A_SIZE = 64'h0000_0000_003F_FFFF,
  parameter logic [63:0] REGION_B_BASE = 64'h0000_0800_0040_0000,
  parameter logic [63:0] REGION_B_SIZE = 64'h0000_0000_007F_FFFF
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             write_i,
  output logic             hit_o,
  output logic [63:0]      rdata_o
);
  logic [31:0] ix;
  logic        rd_hit;
  logic        wr_hit;

  assign ix = 32'(idx_i);

  always_comb begin
    rd_hit  = 1'b1;
    rdata_o = '0;
    case (ix)
      IX_CHIP_ID:   rdata_o = CHIP_ID;
      IX_RGN_A_BAS: rdata_o = REGION_A_BASE;
      IX_RGN_A_SZ:  rdata_o = REGION_A_SIZE;
      IX_RGN_B_BAS: rdata_o = REGION_B_BASE;
      IX_RGN_B_SZ:  rdata_o = REGION_B_SIZE;
      default:      rd_hit  = is_quiet_idx(ix);
    endcase
  end

  // region words are read-only locally; their writes travel downstream
  assign wr_hit = (ix == IX_CHIP_ID) || is_quiet_idx(ix);
  assign hit_o  = write_i ? wr_hit : rd_hit;
endmodule

// File: rtl/scb_status.sv
module scb_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_done_i,
  input  logic       set_fail_i,
  input  logic       clr_wr_i,
  input  logic [1:0] clr_mask_i,
  output logic       done_o,
  output logic       fail_o
);
  logic clr_done, clr_fail;
  assign clr_done = clr_wr_i & clr_mask_i[0];
  assign clr_fail = clr_wr_i & clr_mask_i[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      done_o <= set_done_i | (done_o & ~clr_done);
      fail_o <= set_fail_i | (fail_o & ~clr_fail);
    end
  end
endmodule

// File: rtl/scom_bridge.sv
module scom_bridge
  import scb_pkg::*;
#(
  parameter int          ADDR_W        = 40,
  parameter int          WIN_BITS      = 32,
  parameter int          TIMEOUT_CYC   = 64,
  parameter logic [63:0] CHIP_ID       = 64'h1200_04A6_0000_0049,
  parameter logic [63:0] REGION_A_BASE = 64'h0000_0800_0000_0000,
  parameter logic [63:0] REGION_A_SIZE = 64'h0000_0000_003F_FFFF,
  parameter logic [63:0] REGION_B_BASE = 64'h0000_0800_0040_0000,
  parameter logic [63:0] REGION_B_SIZE = 64'h0000_0000_007F_FFFF,
  localparam int IDX_W = WIN_BITS - 3,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                legacy_mode,
  input  logic                h_valid,
  input  logic                h_write,
  input  logic [ADDR_W-1:0]   h_addr,
  input  logic [63:0]         h_wdata,
  output logic                h_ready,
  output logic [63:0]         h_rdata,
  output logic                d_req,
  output logic                d_write,
  output logic [WIN_BITS-1:0] d_addr,
  output logic [63:0]         d_wdata,
  input  logic                d_ack,
  input  logic                d_err,
  input  logic [63:0]         d_rdata,
  input  logic                st_clr_wr,
  input  logic [1:0]          st_clr_mask,
  output logic                st_done,
  output logic                st_fail
);
  scb_state_e       state;
  logic [IDX_W-1:0] in_idx, cur_idx;
  logic             cur_wr;
  logic [63:0]      cur_wdata, rdata_q, loc_data;
  logic             fail_q, loc_hit;
  logic [CNT_W-1:0] wait_cnt;

  // named events
  logic accept_evt, misalign_evt, local_evt, fwd_evt, resp_evt, timeout_evt, finish_evt;

  scb_addr_fold #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_fold (
    .addr_i(h_addr), .legacy_i(legacy_mode), .idx_o(in_idx)
  );

  scb_local_resp #(
    .IDX_W(IDX_W), .CHIP_ID(CHIP_ID),
    .REGION_A_BASE(REGION_A_BASE), .REGION_A_SIZE(REGION_A_SIZE),
    .REGION_B_BASE(REGION_B_BASE), .REGION_B_SIZE(REGION_B_SIZE)
  ) u_local (
    .idx_i(in_idx), .write_i(h_write), .hit_o(loc_hit), .rdata_o(loc_data)
  );

  assign accept_evt   = (state == ST_IDLE) && h_valid;
  assign misalign_evt = accept_evt && (h_addr[2:0] != 3'b000);
  assign local_evt    = accept_evt && !misalign_evt && loc_hit;
  assign fwd_evt      = accept_evt && !misalign_evt && !loc_hit;
  assign resp_evt     = (state == ST_WAIT) && (d_ack || d_err);
  assign timeout_evt  = (state == ST_WAIT) && !(d_ack || d_err)
                        && (wait_cnt == CNT_W'(TIMEOUT_CYC - 1));
  assign finish_evt   = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_idx   <= '0;
      cur_wr    <= 1'b0;
      cur_wdata <= '0;
      rdata_q   <= '0;
      fail_q    <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (misalign_evt) begin
            rdata_q <= '0;
            fail_q  <= 1'b1;
            state   <= ST_DONE;
          end else if (local_evt) begin
            rdata_q <= h_write ? 64'd0 : loc_data;
            fail_q  <= 1'b0;
            state   <= ST_DONE;
          end else if (fwd_evt) begin
            cur_idx   <= in_idx;
            cur_wr    <= h_write;
            cur_wdata <= h_wdata;
            wait_cnt  <= '0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (resp_evt) begin
            rdata_q <= (d_err || cur_wr) ? 64'd0 : d_rdata;
            fail_q  <= d_err;
            state   <= ST_DONE;
          end else if (timeout_evt) begin
            rdata_q <= '0;
            fail_q  <= 1'b1;
            state   <= ST_DONE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign h_ready = finish_evt;
  assign h_rdata = rdata_q;
  assign d_req   = (state == ST_WAIT);
  assign d_write = cur_wr;
  assign d_addr  = {cur_idx, 3'b000};
  assign d_wdata = cur_wdata;

  scb_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_done_i(finish_evt), .set_fail_i(finish_evt && fail_q),
    .clr_wr_i(st_clr_wr), .clr_mask_i(st_clr_mask),
    .done_o(st_done), .fail_o(st_fail)
  );
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int TIMEOUT_CYC = 64,
  parameter int DA_W        = 32,
  localparam int RUN_W      = $clog2(TIMEOUT_CYC + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            h_ready,
  input logic [63:0]     h_rdata,
  input logic            d_req,
  input logic            d_ack,
  input logic            d_err,
  input logic [DA_W-1:0] d_addr,
  input logic            st_done,
  input logic            st_fail,
  input logic            st_clr_wr,
  input logic [1:0]      st_clr_mask,
  input logic            misalign_evt,
  input logic            local_evt
);
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)     run_q <= '0;
    else if (d_req) run_q <= run_q + 1'b1;
    else            run_q <= '0;
  end

  a_r13_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |=> !h_ready);

  a_r12_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |=> st_done);

  a_r12_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fail && !(st_clr_wr && st_clr_mask[1])) |=> st_fail);

  a_r10_misalign_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_evt |=> (h_ready && !d_req && h_rdata == 64'd0));

  a_r5_local_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    local_evt |=> (h_ready && !d_req));

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ack && !d_err) |=> ((d_req && $stable(d_addr)) || h_ready));

  a_r9_error_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && d_err) |=> (h_ready && h_rdata == 64'd0));

  a_r9_error_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && d_err) |=> ##1 st_fail);

  a_r11_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> (run_q < RUN_W'(TIMEOUT_CYC)));
endmodule

bind scom_bridge scb_checker #(.TIMEOUT_CYC(TIMEOUT_CYC), .DA_W(WIN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_ready(h_ready), .h_rdata(h_rdata),
  .d_req(d_req), .d_ack(d_ack), .d_err(d_err), .d_addr(d_addr),
  .st_done(st_done), .st_fail(st_fail),
  .st_clr_wr(st_clr_wr), .st_clr_mask(st_clr_mask),
  .misalign_evt(misalign_evt), .local_evt(local_evt)
);

// File: tb/tb_scom_bridge.sv
module tb_scom_bridge;
  localparam int ADDR_W = 40;
  localparam int WIN    = 32;
  localparam logic [63:0] CHIP = 64'h1200_04A6_0000_0049;
  localparam logic [63:0] RAB  = 64'h0000_0800_0000_0000;
  localparam logic [63:0] RAS  = 64'h0000_0000_003F_FFFF;
  localparam logic [63:0] RBB  = 64'h0000_0800_0040_0000;
  localparam logic [63:0] RBS  = 64'h0000_0000_007F_FFFF;
  localparam logic [28:0] ERR_IX  = 29'h777;
  localparam logic [28:0] DEAD_IX = 29'h999;

  logic clk = 1'b0, rst_n = 1'b0, legacy_mode = 1'b0;
  logic h_valid = 1'b0, h_write = 1'b0;
  logic [ADDR_W-1:0] h_addr = '0;
  logic [63:0] h_wdata = '0, h_rdata, d_wdata, d_rdata = '0;
  logic h_ready, d_req, d_write, d_ack = 1'b0, d_err = 1'b0;
  logic [WIN-1:0] d_addr;
  logic st_clr_wr = 1'b0, st_done, st_fail;
  logic [1:0] st_clr_mask = 2'b00;

  always #10 clk = ~clk;

  scom_bridge dut (.*);

  int n_cmp = 0, n_bad = 0;
  typedef struct { logic [63:0] d; string t; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read words as completions appear
  always @(negedge clk) begin
    if (rst_n && h_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R13 unexpected completion", h_rdata, 64'd0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(h_rdata == e.d, e.t, h_rdata, e.d);
      end
    end
  end

  // downstream model
  logic [63:0] mem [logic [WIN-1:0]];
  int ds_cnt = 0, delay = 2;
  logic [WIN-1:0] last_daddr = '0;
  always @(negedge clk) begin
    if (d_ack || d_err) begin
      d_ack = 1'b0; d_err = 1'b0;
    end else if (d_req && d_addr != {DEAD_IX, 3'b000}) begin
      if (delay > 0) delay--;
      else begin
        delay = 2; ds_cnt++; last_daddr = d_addr;
        if (d_addr == {ERR_IX, 3'b000}) d_err = 1'b1;
        else begin
          d_ack = 1'b1;
          if (d_write) mem[d_addr] = d_wdata;
          else d_rdata = mem.exists(d_addr) ? mem[d_addr] : {32'hA5A5_0000, d_addr};
        end
      end
    end
  end

  function automatic logic [ADDR_W-1:0] flat_a(input logic [28:0] ix);
    return ADDR_W'({ix, 3'b000});
  endfunction
  function automatic logic [ADDR_W-1:0] leg_a(input logic [28:0] ix);
    return ADDR_W'({ix[27:4], 1'b0, ix[3:0], 3'b000});
  endfunction

  logic post_ready, post_done;
  task automatic acc(input logic wr, input logic [ADDR_W-1:0] a, input logic [63:0] wd,
                     input logic [63:0] exp, input string tag);
    exp_q.push_back('{exp, tag});
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_addr = a; h_wdata = wd;
    do @(negedge clk); while (!h_ready);
    h_valid = 1'b0;
    @(negedge clk);
    post_ready = h_ready; post_done = st_done;
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk); st_clr_wr = 1'b1; st_clr_mask = m;
    @(negedge clk); st_clr_wr = 1'b0; st_clr_mask = 2'b00;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    summary();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk(!h_ready && !d_req && !st_done && !st_fail, "R1 reset state",
        {h_ready, d_req, st_done, st_fail}, 64'd0);
    rst_n = 1'b1;

    // flat mode
    acc(1'b1, flat_a(29'h123), 64'hDEAD_BEEF_0123_4567, 64'd0, "R8 write completion");
    chk(last_daddr == 32'h918, "R2 flat downstream address", last_daddr, 32'h918);
    chk(post_ready == 1'b0, "R13 ready one cycle", post_ready, 64'd0);
    acc(1'b0, flat_a(29'h123), 0, 64'hDEAD_BEEF_0123_4567, "R8 forwarded read data");
    acc(1'b0, flat_a(29'h123) | (40'h1 << 35), 0, 64'hDEAD_BEEF_0123_4567, "R4 high bits ignored");
    chk(st_done && !st_fail, "R12 done set no fail", {st_done, st_fail}, 64'd2);
    clr(2'b01);
    chk(!st_done, "R12 done cleared", st_done, 64'd0);

    c0 = ds_cnt;
    acc(1'b0, flat_a(29'h000F000F), 0, CHIP, "R5 chip id read");
    acc(1'b1, flat_a(29'h000F000F), 64'h55, 64'd0, "R5 chip id write");
    acc(1'b0, flat_a(29'h000F000F), 0, CHIP, "R5 chip id after write");
    chk(ds_cnt == c0, "R5 not forwarded", ds_cnt, c0);

    acc(1'b1, flat_a(29'h00F0034), 64'hFFFF, 64'd0, "R6 quiet write");
    acc(1'b0, flat_a(29'h00F0034), 0, 64'd0, "R6 quiet read after write");
    acc(1'b0, flat_a(29'h0090012), 0, 64'd0, "R6 quiet read");
    acc(1'b0, flat_a(29'h1010C03), 0, 64'd0, "R6 quiet mask read");
    chk(ds_cnt == c0, "R6 not forwarded", ds_cnt, c0);

    acc(1'b0, flat_a(29'h5012B00), 0, RAB, "R7 region A base");
    acc(1'b0, flat_a(29'h5012B04), 0, RAS, "R7 region A size");
    acc(1'b0, flat_a(29'h5012B02), 0, RBB, "R7 region B base");
    acc(1'b0, flat_a(29'h5012B06), 0, RBS, "R7 region B size");
    chk(ds_cnt == c0, "R7 reads local", ds_cnt, c0);
    acc(1'b1, flat_a(29'h5012B00), 64'h77, 64'd0, "R7 region write");
    chk(ds_cnt == c0 + 1 && last_daddr == {29'h5012B00, 3'b000}, "R7 region write forwarded",
        last_daddr, {29'h5012B00, 3'b000});
    chk(mem[{29'h5012B00, 3'b000}] == 64'h77, "R8 write data downstream",
        mem[{29'h5012B00, 3'b000}], 64'h77);

    clr(2'b11);
    acc(1'b0, flat_a(ERR_IX), 0, 64'd0, "R9 error read zero");
    chk(st_fail && st_done, "R9 fail set", {st_done, st_fail}, 64'd3);
    clr(2'b11);
    chk(!st_fail && !st_done, "R12 both cleared", {st_done, st_fail}, 64'd0);

    c0 = ds_cnt;
    acc(1'b0, flat_a(29'h123) | 40'h4, 0, 64'd0, "R10 misaligned read");
    chk(st_fail && ds_cnt == c0 && !d_req, "R10 rejected locally", {st_fail, d_req}, 64'd2);
    clr(2'b11);

    acc(1'b0, flat_a(DEAD_IX), 0, 64'd0, "R11 timeout read zero");
    chk(st_fail && !d_req, "R11 timeout fail, request dropped", {st_fail, d_req}, 64'd2);
    clr(2'b11);

    // legacy mode
    legacy_mode = 1'b1;
    acc(1'b1, leg_a(29'h345), 64'h0BAD_F00D, 64'd0, "R3 legacy write");
    chk(last_daddr == {29'h345, 3'b000}, "R3 legacy downstream address",
        last_daddr, {29'h345, 3'b000});
    acc(1'b0, leg_a(29'h345) | 40'h80, 0, 64'h0BAD_F00D, "R3 bit 7 ignored");
    acc(1'b0, leg_a(29'h000F000F), 0, CHIP, "R3 legacy chip id");

    // set wins over clear
    @(negedge clk); st_clr_wr = 1'b1; st_clr_mask = 2'b11;
    acc(1'b0, leg_a(29'h000F000F), 0, CHIP, "R12 read under clear");
    chk(post_done == 1'b1, "R12 set wins over clear", post_done, 64'd1);
    @(negedge clk);
    chk(!st_done, "R12 clear after set", st_done, 64'd0);
    st_clr_wr = 1'b0; st_clr_mask = 2'b00;

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R13 all completions seen", exp_q.size(), 64'd0);
    summary();
  end
endmodule